// File: doc/BRIEF.md
# Receive Frame Queue with Per-Frame Header

This block sits between a receive MAC and a host bus. The MAC streams the bytes of a frame, CRC included, and then pulses an end strobe together with a 14-bit status value. The queue puts the frame into a shared ring of 16-bit words. The payload is packed two bytes to a word. Once the frame ends, two header words are written ahead of it: a status word and a byte-count word. Only then does the frame become visible to the host.

The host reads the oldest frame through one 16-bit data register. The read address is a word offset from the start of the oldest frame. An access session opens when `dma_on` rises. With auto-increment set, the offset advances by one word on each read strobe. Otherwise the offset is loaded directly. The host frees a frame with an explicit release strobe, or automatically when it reads the frame's last word. The read offset then returns to the next frame's header.

Two further options apply. A big-endian option swaps the two bytes of the header words on the data port. An alignment option stores two zero bytes ahead of the payload, so that an IP header lands on a 32-bit boundary.

Top module: `rxq_hdr_buf`

## Requirements
- R1: After reset, `q_empty` is 1, `q_full` is 0 and `frm_cnt` is 0.
- R2: A stored frame reads as follows, by word offset from its start:
  - Offset 0 holds the status word.
  - Offset 1 holds the count: bits 15:12 are zero and bits 11:0 hold the stored byte count.
  - From offset 2 on, the payload is packed with the earlier byte in bits 7:0. An unused high byte in the last word reads as 0.
- R3: Bytes beyond MAX_LEN are discarded. The count then equals MAX_LEN and status bit 15 is set; otherwise bit 15 is clear.
- R4: `cfg_align` is sampled at the first byte of a frame. When it is set:
  - the word at offset 2 reads as 0 and the payload starts at offset 3;
  - status bit 14 is set;
  - the count excludes the two pad bytes.
  Status bits 13:0 always hold `in_stat`.
- R5: While `cfg_big` is 1, the words at offsets 0 and 1 appear with their bytes swapped. Payload words never are.
- R6: While a session is open, `ptr_wr` loads the offset from `ptr_val`.
  - With `cfg_autoinc` set, each `rd_en` advances the offset by one word.
  - With `cfg_autoinc` clear, `rd_en` leaves the offset unchanged.
- R7: While `dma_on` is 0, `rd_en` and `ptr_wr` have no effect. A rise of `dma_on` returns the offset to 0, and strobes in that first cycle are ignored.
- R8: `rel` removes the oldest frame and decrements `frm_cnt`. The offset returns to 0, which is the next frame's header. `rel` has no effect when the queue is empty.
- R9: With `cfg_autoinc` and `cfg_autodq` both set, a read strobe on the frame's last word releases the frame as in R8.
- R10: `q_full` is 1 while fewer than 2+(MAX_LEN+3)/2 words are free. A frame whose first byte arrives while the queue is full is dropped whole, and `frm_cnt` is unchanged.
- R11: `frm_cnt` rises by one for each stored frame on the third clock edge, counting from the edge that samples `in_end`. A new frame may start after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Frame byte valid |
| in_byte | input | 8 | Frame byte |
| in_end | input | 1 | End-of-frame strobe, never together with in_vld |
| in_stat | input | 14 | Receive status, sampled with in_end |
| cfg_big | input | 1 | Swap header bytes on the data port |
| cfg_autoinc | input | 1 | Advance offset on each read strobe |
| cfg_autodq | input | 1 | Release frame after reading its last word |
| cfg_align | input | 1 | Insert two pad bytes before payload |
| dma_on | input | 1 | Host access session open |
| rd_en | input | 1 | Data register read strobe |
| ptr_wr | input | 1 | Load read offset |
| ptr_val | input | AW | Read offset value in words |
| rel | input | 1 | Release oldest frame |
| rd_data | output | 16 | Data register |
| q_empty | output | 1 | No complete frame stored |
| q_full | output | 1 | Not enough room for a maximum-size frame |
| frm_cnt | output | AW+1 | Number of stored frames |

## Verification
Faults in the ring pointers show up directly at the data port.

- A wrong write base or head misplaces header words, so the very first word read after a session opens carries the wrong status or count.
- An error in the stored length breaks the jump to the next frame. It is exposed only on the word read after a release, one frame later.
- A wrong free-space figure shows up on `q_full` before the next frame starts. That frame is then dropped, or accepted, wrongly, and `frm_cnt` differs three edges after its end strobe.

// File: rtl/rxq_hdr_buf.sv
module rxq_hdr_buf #(
  parameter int AW      = 11,
  parameter int MAX_LEN = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [7:0]    in_byte,
  input  logic          in_end,
  input  logic [13:0]   in_stat,
  input  logic          cfg_big,
  input  logic          cfg_autoinc,
  input  logic          cfg_autodq,
  input  logic          cfg_align,
  input  logic          dma_on,
  input  logic          rd_en,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_val,
  input  logic          rel,
  output logic [15:0]   rd_data,
  output logic          q_empty,
  output logic          q_full,
  output logic [AW:0]   frm_cnt
);
  localparam int DEPTH = 1 << AW;
  localparam int FRM_W = 2 + (MAX_LEN + 3) / 2;
  localparam logic [AW+1:0] DEPTH_L = (AW+2)'(DEPTH);
  localparam logic [AW+1:0] FRM_L   = (AW+2)'(FRM_W);
  localparam logic [11:0]   MAXL    = 12'(MAX_LEN);
  localparam logic [2:0] S_IDLE = 3'd0, S_RECV = 3'd1, S_DROP = 3'd2,
                         S_STAT = 3'd3, S_CNT  = 3'd4;

  logic [15:0]   mem [DEPTH];
  logic [2:0]    st;
  logic [AW:0]   wbase, head, fcount;
  logic [AW-1:0] roff;
  logic [11:0]   n;
  logic [7:0]    lo;
  logic          pad, trunc, dma_q;
  logic [13:0]   stat_q;
  logic          we;
  logic [AW-1:0] wa;
  logic [15:0]   wd;

  wire [12:0]   pos    = {1'b0, n} + (pad ? 13'd2 : 13'd0);
  wire [AW-1:0] pay_a  = wbase[AW-1:0] + AW'(2) + AW'(pos[12:1]);
  wire [AW:0]   fw_new = (AW+1)'((pos + 13'd1) >> 1) + (AW+1)'(2);
  wire [AW:0]   used   = wbase - head;

  assign q_full  = ({1'b0, used} + FRM_L) > DEPTH_L;
  assign q_empty = (fcount == '0);
  assign frm_cnt = fcount;

  wire [AW-1:0] head_a = head[AW-1:0];
  wire [11:0]   h_cnt  = mem[head_a + AW'(1)][11:0];
  wire          h_pad  = mem[head_a][14];
  wire [AW:0]   h_fw   = (AW+1)'(({1'b0, h_cnt} + (h_pad ? 13'd2 : 13'd0) + 13'd1) >> 1)
                         + (AW+1)'(2);
  wire [15:0]   rword  = mem[head_a + roff];
  wire          in_hdr = (roff < AW'(2));

  assign rd_data = (cfg_big && in_hdr) ? {rword[7:0], rword[15:8]} : rword;

  wire          open_s   = dma_on && dma_q;
  wire          access   = open_s && rd_en && !q_empty;
  wire [AW:0]   nxt_off  = {1'b0, roff} + (AW+1)'(1);
  wire          auto_rel = access && cfg_autoinc && cfg_autodq && (nxt_off == h_fw);
  wire          do_rel   = !q_empty && (rel || auto_rel);
  wire          commit   = (st == S_CNT);

  always_comb begin
    we = 1'b0;
    wa = pay_a;
    wd = {in_byte, lo};
    case (st)
      S_IDLE: if (in_vld && !q_full && cfg_align) begin
        we = 1'b1;
        wa = wbase[AW-1:0] + AW'(2);
        wd = 16'h0000;
      end
      S_RECV: if (in_end) begin
        we = pos[0];
        wd = {8'h00, lo};
      end else if (in_vld && n < MAXL && pos[0]) begin
        we = 1'b1;
      end
      S_STAT: begin
        we = 1'b1;
        wa = wbase[AW-1:0];
        wd = {trunc, pad, stat_q};
      end
      S_CNT: begin
        we = 1'b1;
        wa = wbase[AW-1:0] + AW'(1);
        wd = {4'h0, n};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk)
    if (we) mem[wa] <= wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wbase  <= '0;
      n      <= '0;
      lo     <= '0;
      pad    <= 1'b0;
      trunc  <= 1'b0;
      stat_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_vld) begin
          if (!q_full) begin
            st    <= S_RECV;
            n     <= 12'd1;
            lo    <= in_byte;
            pad   <= cfg_align;
            trunc <= 1'b0;
          end else begin
            st <= S_DROP;
          end
        end
        S_RECV: if (in_end) begin
          stat_q <= in_stat;
          st     <= S_STAT;
        end else if (in_vld) begin
          if (n < MAXL) begin
            n <= n + 12'd1;
            if (!pos[0]) lo <= in_byte;
          end else begin
            trunc <= 1'b1;
          end
        end
        S_DROP: if (in_end) st <= S_IDLE;
        S_STAT: st <= S_CNT;
        S_CNT: begin
          wbase <= wbase + fw_new;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head   <= '0;
      roff   <= '0;
      fcount <= '0;
      dma_q  <= 1'b0;
    end else begin
      dma_q <= dma_on;
      if (do_rel) begin
        head <= head + h_fw;
        roff <= '0;
      end else if (dma_on && !dma_q) begin
        roff <= '0;
      end else if (open_s && ptr_wr) begin
        roff <= ptr_val;
      end else if (access && cfg_autoinc) begin
        roff <= roff + AW'(1);
      end
      case ({commit, do_rel})
        2'b10:   fcount <= fcount + (AW+1)'(1);
        2'b01:   fcount <= fcount - (AW+1)'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rxq_hdr_buf_chk.sv
module rxq_hdr_buf_chk #(
  parameter int AW      = 11,
  parameter int MAX_LEN = 2000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic          rel,
  input logic          dma_on,
  input logic          dma_q,
  input logic          ptr_wr,
  input logic          cfg_autoinc,
  input logic          q_empty,
  input logic          q_full,
  input logic [AW:0]   frm_cnt,
  input logic [2:0]    st,
  input logic [AW-1:0] roff,
  input logic [11:0]   n
);
  // R8
  rel_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && !q_empty && st != 3'd4) |=> frm_cnt == $past(frm_cnt) - 1'b1);

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && in_vld && q_full) |=> st == 3'd2);

  // R7
  idle_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_on && !rel) |=> $stable(roff));

  // R6
  hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_on && dma_q && !cfg_autoinc && !ptr_wr && !rel) |=> $stable(roff));

  // R3
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n <= 12'(MAX_LEN));

  // R11
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 3'd4) |=> frm_cnt <= $past(frm_cnt));
endmodule

bind rxq_hdr_buf rxq_hdr_buf_chk #(.AW(AW), .MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .rel(rel), .dma_on(dma_on),
  .dma_q(dma_q), .ptr_wr(ptr_wr), .cfg_autoinc(cfg_autoinc),
  .q_empty(q_empty), .q_full(q_full), .frm_cnt(frm_cnt), .st(st),
  .roff(roff), .n(n)
);

// File: tb/rxq_hdr_buf_test.sv
`timescale 1ns/100ps
module rxq_hdr_buf_test;
  localparam int AW = 6;
  localparam int ML = 40;
  localparam int DEP = 64;
  localparam int FW_MAX = 2 + (ML + 3) / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_vld = 0, in_end = 0, cfg_big = 0, cfg_autoinc = 0, cfg_autodq = 0, cfg_align = 0;
  logic dma_on = 0, rd_en = 0, ptr_wr = 0, rel = 0;
  logic [7:0] in_byte = 0;
  logic [13:0] in_stat = 0;
  logic [AW-1:0] ptr_val = 0;
  logic [15:0] rd_data;
  logic q_empty, q_full;
  logic [AW:0] frm_cnt;

  rxq_hdr_buf #(.AW(AW), .MAX_LEN(ML)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte), .in_end(in_end),
    .in_stat(in_stat), .cfg_big(cfg_big), .cfg_autoinc(cfg_autoinc),
    .cfg_autodq(cfg_autodq), .cfg_align(cfg_align), .dma_on(dma_on), .rd_en(rd_en),
    .ptr_wr(ptr_wr), .ptr_val(ptr_val), .rel(rel), .rd_data(rd_data),
    .q_empty(q_empty), .q_full(q_full), .frm_cnt(frm_cnt));

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  int m_cnt[32];
  logic [13:0] m_stat[32];
  bit m_pad[32], m_tr[32];
  logic [7:0] m_b[32][64];
  int qh = 0, qn = 0, used = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bt(int i, int p);
    return (p >= 0 && p < m_cnt[i]) ? m_b[i][p] : 8'h00;
  endfunction

  function automatic int fw_of(int i);
    return 2 + (m_cnt[i] + (m_pad[i] ? 2 : 0) + 1) / 2;
  endfunction

  function automatic logic [15:0] ew(int i, int off, bit big);
    logic [15:0] w;
    int p;
    if (off == 0) w = {m_tr[i], m_pad[i], m_stat[i]};
    else if (off == 1) w = {4'h0, 12'(m_cnt[i])};
    else begin
      p = (off - 2) * 2 - (m_pad[i] ? 2 : 0);
      w = {bt(i, p + 1), bt(i, p)};
    end
    if (big && off < 2) w = {w[7:0], w[15:8]};
    return w;
  endfunction

  task automatic send(int len, bit al, logic [13:0] s);
    bit acc;
    int slot;
    logic [7:0] b;
    @(negedge clk);
    cfg_align = al;
    chk("R10 full flag", 32'(q_full), 32'((DEP - used) < FW_MAX));
    acc = (DEP - used) >= FW_MAX;
    slot = (qh + qn) % 32;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      b = 8'($urandom);
      in_vld = 1; in_byte = b;
      if (acc && k < ML) m_b[slot][k] = b;
    end
    @(negedge clk);
    in_vld = 0; in_end = 1; in_stat = s;
    @(negedge clk);
    in_end = 0;
    repeat (3) @(negedge clk);
    if (acc) begin
      m_cnt[slot] = (len > ML) ? ML : len;
      m_tr[slot] = (len > ML);
      m_pad[slot] = al;
      m_stat[slot] = s;
      qn++;
      used += fw_of(slot);
      chk("R11 frame count after store", 32'(frm_cnt), 32'(qn));
    end else begin
      chk("R10 dropped frame not counted", 32'(frm_cnt), 32'(qn));
    end
  endtask

  task automatic read_frame(bit big, bit adq);
    int fw;
    string req;
    fw = fw_of(qh);
    cfg_big = big; cfg_autoinc = 1; cfg_autodq = adq;
    @(negedge clk); dma_on = 1;
    @(negedge clk);
    for (int off = 0; off < fw; off++) begin
      if (off < 2 && big) req = "R5 swapped header";
      else if (off == 0 && m_tr[qh]) req = "R3 truncation status";
      else if (off == 2 && m_pad[qh]) req = "R4 pad word";
      else req = "R2 frame word";
      chk(req, 32'(rd_data), 32'(ew(qh, off, big)));
      rd_en = 1;
      @(negedge clk); rd_en = 0;
    end
    if (!adq) begin
      rel = 1;
      @(negedge clk); rel = 0;
    end
    used -= fw;
    qh = (qh + 1) % 32; qn--;
    chk(adq ? "R9 auto release count" : "R8 release count", 32'(frm_cnt), 32'(qn));
    dma_on = 0; cfg_big = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'd7331);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 empty", 32'(q_empty), 1);
    chk("R1 full", 32'(q_full), 0);
    chk("R1 count", 32'(frm_cnt), 0);
    rel = 1; @(negedge clk); rel = 0;
    chk("R8 release on empty", 32'(frm_cnt), 0);
    chk("R8 empty stays", 32'(q_empty), 1);

    send(5, 0, 14'h1234);
    send(8, 1, 14'h0abc);
    cfg_autoinc = 0; dma_on = 1;
    @(negedge clk);
    chk("R2 status word", 32'(rd_data), 32'(ew(qh, 0, 0)));
    rd_en = 1; @(negedge clk); rd_en = 0; @(negedge clk);
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk("R6 hold without autoinc", 32'(rd_data), 32'(ew(qh, 0, 0)));
    ptr_wr = 1; ptr_val = 3; @(negedge clk); ptr_wr = 0;
    chk("R6 pointer load", 32'(rd_data), 32'(ew(qh, 3, 0)));
    dma_on = 0; cfg_autoinc = 1;
    rd_en = 1; ptr_wr = 1; ptr_val = 1; @(negedge clk); rd_en = 0; ptr_wr = 0;
    chk("R7 ignored outside session", 32'(rd_data), 32'(ew(qh, 3, 0)));
    dma_on = 1; @(negedge clk);
    chk("R7 session start offset", 32'(rd_data), 32'(ew(qh, 0, 0)));
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk("R6 autoinc step", 32'(rd_data), 32'(ew(qh, 1, 0)));
    rd_en = 1; @(negedge clk); rd_en = 0;
    rel = 1; @(negedge clk); rel = 0;
    used -= fw_of(qh); qh = (qh + 1) % 32; qn--;
    chk("R8 mid-frame release count", 32'(frm_cnt), 32'(qn));
    chk("R8 next header", 32'(rd_data), 32'(ew(qh, 0, 0)));
    dma_on = 0;
    read_frame(1, 0);

    send(45, 0, 14'h3fff);
    read_frame(0, 1);
    send(7, 1, 14'h0001);
    read_frame(1, 1);

    while ((DEP - used) >= FW_MAX) send(ML, 0, 14'(qn));
    chk("R10 full asserted", 32'(q_full), 1);
    send(10, 0, 14'h0055);
    while (qn > 0) read_frame(bit'($urandom), bit'($urandom));

    for (int it = 0; it < 300; it++) begin
      if (qn > 0 && ($urandom % 2 == 1 || qn > 10))
        read_frame(bit'($urandom), bit'($urandom));
      else
        send(1 + int'($urandom % 50), bit'($urandom), 14'($urandom));
    end
    while (qn > 0) read_frame(bit'($urandom), bit'($urandom));
    chk("R8 drained", 32'(q_empty), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule